// File: doc/BRIEF.md
# Countdown Timer Bank

A bank of four independent countdown timers that sit behind a 32-bit register window. Every timer has a base count that software programs. Bit 31 of that base count is an inhibit control. The current count is read-only and carries a toggle flag in its top bit. A shared tick enable advances all running timers. When a timer's count expires, the timer reloads from its base count, inverts its toggle flag and raises a single-cycle expiry strobe on its own output line. That line feeds an interrupt source.

The block also decodes the two upper registers of each timer's window: the interrupt vector/priority word and the destination word. It does not hold them. A write to either one is passed to an external source-configuration port. A read of either one returns the word that port supplies. Timers are released by clearing the inhibit bit. The first tick after a release loads the count from the base value.

Top module: `tmr_bank`

## Requirements
- R1: After reset every current count reads 0x0000_0000, every base count reads 0x8000_0000 and all expiry outputs are low.
- R2: Address bits 7:6 select the timer, and address bits 5:4 select its register: 0 is the current count, 1 is the base count, 2 is vector/priority and 3 is destination. A base write stores all 32 bits, and a later read returns them.
- R3: A write to the current count offset changes neither the count nor the toggle flag.
- R4: While bit 31 of a timer's base count is set, its count holds and its expiry output stays low, even when tick is high.
- R5: After a write clears bit 31 of a base count that had it set, the first tick loads count bits 30:0 from the base. That tick raises no expiry.
- R6: A running timer that sees a tick with a count above 1 decrements by one. A tick with a count of 0 or 1 reloads the count from the base, inverts bit 31 of the current count register and drives that timer's expiry output high for exactly the next cycle.
- R7: In a cycle without tick, no count changes and every expiry output is low in the following cycle.
- R8: A base write with bit 31 clear resets the toggle flag only when the old base had bit 31 set. A base write to a running timer leaves the toggle flag unchanged.
- R9: A write to offset 2 or 3 asserts cfg_wr in the same cycle, with cfg_idx equal to the timer index, cfg_sel at 0 for offset 2 and 1 for offset 3, and cfg_wdata equal to wr_data. It leaves every base count untouched.
- R10: A read at offset 2 or 3 returns cfg_rdata on rd_data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable shared by all timers |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| expire | output | 4 | Per-timer single-cycle expiry strobe |
| cfg_wr | output | 1 | Forwarded write to source configuration |
| cfg_idx | output | 2 | Timer index of the forwarded access |
| cfg_sel | output | 1 | 0 vector/priority, 1 destination |
| cfg_wdata | output | 32 | Forwarded write data |
| cfg_rdata | input | 32 | Source configuration read data |

## Verification
The directed patterns come first. Reads at reset show the reset values, and writes to the read-only count show whether that write reaches storage. Ticks applied while inhibited separate a held count from a running one. A release with a base of 3 followed by a steady tick shows the load cycle, the decrements and the wrap period. A base of 0 gives an expiry on every tick, which exposes off-by-one errors in the wrap test. Two toggle-clearing cases separate a release from a plain rewrite. After these, about 400 cycles of random ticks, base writes with random inhibit bits and reads at random offsets are compared every clock against a behavioural model. They cover releases that collide with ticks and timers that run at the same time.

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int NUM_TMR = 4,
  parameter int DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             wr_en,
  input  logic [$clog2(NUM_TMR)+5:0]       addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [DATA_W-1:0]                rd_data,
  output logic [NUM_TMR-1:0]               expire,
  output logic                             cfg_wr,
  output logic [$clog2(NUM_TMR)-1:0]       cfg_idx,
  output logic                             cfg_sel,
  output logic [DATA_W-1:0]                cfg_wdata,
  input  logic [DATA_W-1:0]                cfg_rdata
);
  localparam int IDX_W = $clog2(NUM_TMR);
  localparam int CNT_W = DATA_W - 1;

  logic [NUM_TMR-1:0][DATA_W-1:0] base_q;
  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_TMR-1:0]             tog_q, pend_q, expire_q;

  wire [IDX_W-1:0] sel_idx = addr[6 +: IDX_W];
  wire [1:0]       sel_off = addr[5:4];

  assign cfg_wr    = wr_en && sel_off[1];
  assign cfg_idx   = sel_idx;
  assign cfg_sel   = sel_off[0];
  assign cfg_wdata = wr_data;
  assign expire    = expire_q;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    wire hit   = wr_en && (sel_off == 2'b01) && (sel_idx == IDX_W'(t));
    wire inh   = base_q[t][DATA_W-1];
    wire rel_w = hit && !wr_data[DATA_W-1] && inh;
    wire run   = tick && !inh;
    wire wrap  = run && !pend_q[t] && (cnt_q[t] <= CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[t]   <= {1'b1, {CNT_W{1'b0}}};
        cnt_q[t]    <= '0;
        tog_q[t]    <= 1'b0;
        pend_q[t]   <= 1'b0;
        expire_q[t] <= 1'b0;
      end else begin
        expire_q[t] <= wrap;
        if (run) begin
          if (pend_q[t] || wrap) cnt_q[t] <= base_q[t][CNT_W-1:0];
          else                   cnt_q[t] <= cnt_q[t] - CNT_W'(1);
        end
        if (rel_w)    pend_q[t] <= 1'b1;
        else if (run) pend_q[t] <= 1'b0;
        if (wrap)       tog_q[t] <= ~tog_q[t];
        else if (rel_w) tog_q[t] <= 1'b0;
        if (hit) base_q[t] <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (sel_off)
      2'b00:   rd_data = {tog_q[sel_idx], cnt_q[sel_idx]};
      2'b01:   rd_data = base_q[sel_idx];
      default: rd_data = cfg_rdata;
    endcase
  end
endmodule

module tmr_bank_chk #(
  parameter int NUM_TMR = 4,
  parameter int DATA_W  = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             tick,
  input logic                             wr_en,
  input logic                             cfg_zone,
  input logic [NUM_TMR-1:0]               expire,
  input logic [NUM_TMR-1:0][DATA_W-1:0]   base_q,
  input logic [NUM_TMR-1:0][DATA_W-2:0]   cnt_q,
  input logic [NUM_TMR-1:0]               tog_q
);
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    assert_hold_while_inhibited_R4: assert property (@(posedge clk) disable iff (!rst_n)
      base_q[t][DATA_W-1] |=> (cnt_q[t] == $past(cnt_q[t]) && !expire[t]));
    assert_expire_flips_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      expire[t] |-> (tog_q[t] != $past(tog_q[t])));
  end

  assert_idle_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt_q) && expire == '0));

  assert_toggle_needs_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(tog_q));

  assert_forward_keeps_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_zone) |=> $stable(base_q));
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_TMR(NUM_TMR), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .cfg_zone(addr[5]),
  .expire(expire), .base_q(base_q), .cnt_q(cnt_q), .tog_q(tog_q)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  expire;
  logic        cfg_wr;
  logic [1:0]  cfg_idx;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;

  int vectors = 0;
  int misses = 0;
  string req = "R1";

  logic [31:0] m_base [4];
  logic [30:0] m_cnt  [4];
  bit          m_tog  [4];
  bit          m_pend [4];
  bit          m_exp  [4];

  always #4 clk = ~clk;

  assign cfg_rdata = {16'hA5C3, 8'h00, addr};

  tmr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .expire(expire), .cfg_wr(cfg_wr),
    .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s (%s): actual 0x%08h expected 0x%08h", req, tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [7:0] a);
    int t = int'(a[7:6]);
    case (a[5:4])
      2'd0:    return {m_tog[t], m_cnt[t]};
      2'd1:    return m_base[t];
      default: return {16'hA5C3, 8'h00, a};
    endcase
  endfunction

  task automatic step(bit tk, bit we, logic [7:0] a, logic [31:0] d);
    tick = tk; wr_en = we; addr = a; wr_data = d;
    #1;
    // R9 forwarded write path, R10 read path
    if (we && a[5]) begin
      check("cfg_wr R9", 32'(cfg_wr), 32'd1);
      check("cfg_idx R9", 32'(cfg_idx), 32'(a[7:6]));
      check("cfg_sel R9", 32'(cfg_sel), 32'(a[4]));
      check("cfg_wdata R9", cfg_wdata, d);
    end else begin
      check("cfg_wr idle R9", 32'(cfg_wr), 32'd0);
    end
    @(posedge clk);
    for (int t = 0; t < 4; t++) begin
      bit inh = m_base[t][31];
      m_exp[t] = 1'b0;
      if (tk && !inh) begin
        if (m_pend[t]) begin
          m_cnt[t] = m_base[t][30:0];
          m_pend[t] = 1'b0;
        end else if (m_cnt[t] <= 31'd1) begin
          m_cnt[t] = m_base[t][30:0];
          m_tog[t] = !m_tog[t];
          m_exp[t] = 1'b1;
        end else begin
          m_cnt[t] = m_cnt[t] - 31'd1;
        end
      end
      if (we && a[5:4] == 2'd1 && int'(a[7:6]) == t) begin
        if (!d[31] && inh) begin
          m_pend[t] = 1'b1;
          m_tog[t] = 1'b0;
        end
        m_base[t] = d;
      end
    end
    @(negedge clk);
    check("expire", 32'(expire), 32'({m_exp[3], m_exp[2], m_exp[1], m_exp[0]}));
    check("rd_data", rd_data, model_read(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int t = 0; t < 4; t++) begin
      m_base[t] = 32'h8000_0000; m_cnt[t] = '0; m_tog[t] = 0; m_pend[t] = 0; m_exp[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    req = "R1";
    for (int t = 0; t < 4; t++) begin
      step(0, 0, {2'(t), 2'd0, 4'h0}, '0);
      step(0, 0, {2'(t), 2'd1, 4'h0}, '0);
    end

    req = "R3";
    step(0, 1, 8'h40, 32'hFFFF_FFFF);
    step(1, 1, 8'h40, 32'h7FFF_FFFF);

    req = "R2";
    step(0, 1, 8'h90, 32'h8000_0005);
    step(0, 0, 8'h90, '0);
    step(0, 1, 8'hD0, 32'h8123_4567);
    step(0, 0, 8'hD0, '0);

    req = "R4";
    for (int k = 0; k < 5; k++) step(1, 0, {2'(k % 4), 2'd0, 4'h0}, '0);

    req = "R5";
    step(0, 1, 8'h10, 32'h0000_0003);
    step(1, 0, 8'h00, '0);

    req = "R6";
    for (int k = 0; k < 7; k++) step(1, 0, 8'h00, '0);

    req = "R7";
    for (int k = 0; k < 3; k++) step(0, 0, 8'h00, '0);

    req = "R8";
    step(0, 1, 8'h10, 32'h0000_0004);
    step(0, 0, 8'h00, '0);
    step(0, 1, 8'h10, 32'h8000_0003);
    step(0, 1, 8'h10, 32'h0000_0003);
    step(1, 0, 8'h00, '0);

    req = "R6";
    step(0, 1, 8'h50, 32'h0000_0000);
    for (int k = 0; k < 4; k++) step(1, 0, 8'h40, '0);

    req = "R9";
    step(0, 1, 8'h60, 32'hDEAD_0001);
    step(0, 1, 8'hF0, 32'hBEEF_0002);
    step(0, 0, 8'hD0, '0);

    req = "R10";
    step(0, 0, 8'hA0, '0);
    step(0, 0, 8'h30, '0);

    req = "R6";
    for (int k = 0; k < 400; k++) begin
      bit tk = ($urandom % 3) != 0;
      bit we = ($urandom % 6) == 0;
      logic [7:0] a = {2'($urandom % 4), 2'($urandom % 4), 4'h0};
      logic [31:0] d = {1'(($urandom % 4) == 0), 27'd0, 4'($urandom % 16)};
      step(tk, we, a, d);
    end

    tick = 0; wr_en = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule